// File: doc/BRIEF.md
# Selectable Prescaler and Programmable Divide-by-N Front End

This block is the feedback-division path of a phase-locked frequency synthesizer. It runs from one system clock, which acts as the input clock of the prescaler. A fixed-ratio prescaler divides that clock by 4, 16, 64 or 100, picked by a 2-bit select. It emits a one-cycle pulse for each ratio period. A 4-bit programmable down-counter then divides a stream of step events by a preset value N from 1 to 15.

A route control sets where each part gets its input and where its output goes. In cascaded mode the prescaler pulses step the N-divider, and the N-divider's terminal pulse becomes the feedback signal for the phase comparator, so the feedback period is ratio × N clocks. In independent mode the prescaler pulse goes straight to the feedback output. The N-divider is then stepped by an auxiliary step strobe, so it can serve an external counter chain.

The N-divider is a three-state machine: ND_LOAD, ND_RUN and ND_HALT. Reset puts it in ND_LOAD. From ND_LOAD it goes to ND_RUN when the preset is nonzero, or to ND_HALT when the preset is zero. ND_RUN stays in ND_RUN and reloads on each wrap. From ND_RUN or ND_HALT, a preset-load strobe moves it to ND_RUN (nonzero preset) or to ND_HALT (zero preset). A zero preset is illegal: ND_HALT raises an error flag and the divider produces no pulses.

Top module: `synth_clk_divider`

## Requirements
- R1: `ratio_sel` picks the prescaler ratio: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 64 and 2'b11 gives 100 clocks between successive `casc_out` pulses.
- R2: When `ratio_sel` changes, the prescaler count restarts from zero. With the new select presented after a clock edge, the first pulse at the new ratio R is visible R clocks later.
- R3: `casc_out` is high for exactly one clock per prescaler period.
- R4: With `route_casc`=1, each `casc_out` pulse steps the N-divider, and `fb_out` carries `zero_pulse`. The `fb_out` period is ratio × N clocks for every N from 1 to 15.
- R5: With `route_casc`=0, `fb_out` carries the prescaler pulse (period = ratio), and the N-divider is stepped by `aux_step`. `zero_pulse` then recurs every N steps.
- R6: `zero_pulse` is one clock wide and coincides with the step that ends a count of N. In cascaded mode it coincides with a `casc_out` pulse.
- R7: Loading N = 0 raises `n_error` in the next clock, and no `zero_pulse` or cascaded `fb_out` pulse occurs while the error holds.
- R8: Loading a nonzero N, via `preset_load` or the state that follows reset, clears `n_error` and restarts the count. With a step in every clock, the first `zero_pulse` is visible at the N-th clock after the load clock edge. Steps in the load clock are not counted.
- R9: A synchronous active-high `rst` drives `casc_out`, `zero_pulse`, `fb_out` and `n_error` low. The first clock after release loads `n_preset`.
- R10: In cascaded mode `aux_step` has no effect on the `fb_out` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, input to the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Prescaler ratio select (00:4, 01:16, 10:64, 11:100) |
| route_casc | input | 1 | 1: cascaded mode, 0: independent mode |
| n_preset | input | 4 | Divide-by-N preset value |
| preset_load | input | 1 | Load strobe for `n_preset` |
| aux_step | input | 1 | Step strobe for the N-divider in independent mode |
| fb_out | output | 1 | Feedback pulse toward the phase comparator |
| zero_pulse | output | 1 | Terminal-count pulse of the N-divider |
| casc_out | output | 1 | Prescaler pulse, for an external counter chain |
| n_error | output | 1 | High while an illegal N = 0 is loaded |

## Verification
The main division path is swept over all four selects and all fifteen legal N in both routes. The cascaded sweep shows that the N-divider is stepped only by prescaler pulses, giving a ratio × N period. The independent sweep shows that the feedback path bypasses the N-divider, and that the N-divider follows the auxiliary strobe alone. A vector table with sparse and dense `aux_step` patterns separates step-driven counting from clock-driven counting, and shows in cascaded mode that the strobe is ignored. Directed cases cover these timings:
- the pulse latency after a select change, which tells a restart from a counter left to run past the new terminal value;
- the latency of the first terminal pulse after a load and after reset;
- the silence and the flag that follow a zero preset.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [1:0] {
        ND_LOAD = 2'd0,
        ND_RUN  = 2'd1,
        ND_HALT = 2'd2
    } ndiv_state_t;

    localparam int DEF_RATIO0 = 4;
    localparam int DEF_RATIO1 = 16;
    localparam int DEF_RATIO2 = 64;
    localparam int DEF_RATIO3 = 100;
    localparam int DEF_N_W    = 4;

endpackage

// File: rtl/pll_prescaler.sv
module pll_prescaler #(
    parameter int RATIO0 = synth_div_pkg::DEF_RATIO0,
    parameter int RATIO1 = synth_div_pkg::DEF_RATIO1,
    parameter int RATIO2 = synth_div_pkg::DEF_RATIO2,
    parameter int RATIO3 = synth_div_pkg::DEF_RATIO3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    output logic       pre_pulse
);
    localparam int RMAX01 = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
    localparam int RMAX23 = (RATIO2 > RATIO3) ? RATIO2 : RATIO3;
    localparam int RMAX   = (RMAX01 > RMAX23) ? RMAX01 : RMAX23;
    localparam int CNT_W  = (RMAX > 2) ? $clog2(RMAX) : 1;

    logic [1:0]       sel_q;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] pcnt_nxt;
    logic [CNT_W-1:0] last_cnt;

    // terminal count for the currently active ratio
    always_comb begin
        unique case (sel_q)
            2'd0:    last_cnt = CNT_W'(RATIO0 - 1);
            2'd1:    last_cnt = CNT_W'(RATIO1 - 1);
            2'd2:    last_cnt = CNT_W'(RATIO2 - 1);
            default: last_cnt = CNT_W'(RATIO3 - 1);
        endcase
    end

    always_comb begin
        if (ratio_sel != sel_q) begin
            pcnt_nxt = '0;
        end else if (pcnt == last_cnt) begin
            pcnt_nxt = '0;
        end else begin
            pcnt_nxt = pcnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= ratio_sel;
            pcnt  <= '0;
        end else begin
            sel_q <= ratio_sel;
            pcnt  <= pcnt_nxt;
        end
    end

    assign pre_pulse = (pcnt == last_cnt);

endmodule

// File: rtl/ndiv_counter.sv
module ndiv_counter
    import synth_div_pkg::*;
#(
    parameter int N_W = synth_div_pkg::DEF_N_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic           preset_load,
    input  logic [N_W-1:0] n_preset,
    output logic           zero_pulse,
    output logic           n_error
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    ndiv_state_t    state_q, state_d;
    logic [N_W-1:0] cnt_q, cnt_d;
    logic [N_W-1:0] n_q, n_d;
    logic           load_now;

    assign load_now = preset_load || (state_q == ND_LOAD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        n_d     = n_q;
        if (load_now) begin
            n_d = n_preset;
            if (n_preset == '0) begin
                state_d = ND_HALT;
            end else begin
                state_d = ND_RUN;
                cnt_d   = n_preset - ONE;
            end
        end else begin
            unique case (state_q)
                ND_RUN: begin
                    if (step) begin
                        cnt_d = (cnt_q == '0) ? (n_q - ONE) : (cnt_q - ONE);
                    end
                end
                ND_HALT: begin
                    state_d = ND_HALT;
                end
                default: begin
                    state_d = ND_LOAD;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ND_LOAD;
            cnt_q   <= '0;
            n_q     <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            n_q     <= n_d;
        end
    end

    // outputs
    always_comb begin
        zero_pulse = 1'b0;
        n_error    = 1'b0;
        unique case (state_q)
            ND_RUN:  zero_pulse = step && (cnt_q == '0);
            ND_HALT: n_error    = 1'b1;
            default: zero_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/div_route.sv
module div_route (
    input  logic route_casc,
    input  logic pre_pulse,
    input  logic aux_step,
    input  logic zero_pulse,
    output logic ndiv_step,
    output logic fb_out
);
    always_comb begin
        if (route_casc) begin
            ndiv_step = pre_pulse;
            fb_out    = zero_pulse;
        end else begin
            ndiv_step = aux_step;
            fb_out    = pre_pulse;
        end
    end
endmodule

// File: rtl/synth_clk_divider.sv
module synth_clk_divider #(
    parameter int RATIO0 = synth_div_pkg::DEF_RATIO0,
    parameter int RATIO1 = synth_div_pkg::DEF_RATIO1,
    parameter int RATIO2 = synth_div_pkg::DEF_RATIO2,
    parameter int RATIO3 = synth_div_pkg::DEF_RATIO3,
    parameter int N_W    = synth_div_pkg::DEF_N_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     ratio_sel,
    input  logic           route_casc,
    input  logic [N_W-1:0] n_preset,
    input  logic           preset_load,
    input  logic           aux_step,
    output logic           fb_out,
    output logic           zero_pulse,
    output logic           casc_out,
    output logic           n_error
);
    logic pre_pulse;
    logic ndiv_step;

    pll_prescaler #(
        .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3)
    ) pre_i (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .pre_pulse (pre_pulse)
    );

    div_route route_i (
        .route_casc (route_casc),
        .pre_pulse  (pre_pulse),
        .aux_step   (aux_step),
        .zero_pulse (zero_pulse),
        .ndiv_step  (ndiv_step),
        .fb_out     (fb_out)
    );

    ndiv_counter #(.N_W(N_W)) ndiv_i (
        .clk         (clk),
        .rst         (rst),
        .step        (ndiv_step),
        .preset_load (preset_load),
        .n_preset    (n_preset),
        .zero_pulse  (zero_pulse),
        .n_error     (n_error)
    );

    assign casc_out = pre_pulse;

endmodule

// File: rtl/synth_clk_divider_chk.sv
module synth_clk_divider_chk #(
    parameter int N_W = synth_div_pkg::DEF_N_W
) (
    input logic           clk,
    input logic           rst,
    input logic           route_casc,
    input logic [N_W-1:0] n_preset,
    input logic           preset_load,
    input logic           casc_out,
    input logic           zero_pulse,
    input logic           n_error
);
    // R3: prescaler pulse never lasts two clocks
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        casc_out |=> !casc_out);

    // R6: cascaded terminal pulse lines up with a prescaler pulse
    a_r6_zero_on_step: assert property (@(posedge clk) disable iff (rst)
        (route_casc && zero_pulse) |-> casc_out);

    // R7: loading zero raises the error flag
    a_r7_zero_flags: assert property (@(posedge clk) disable iff (rst)
        (preset_load && (n_preset == '0)) |=> n_error);

    // R7: no terminal pulse while the error holds
    a_r7_silent_halt: assert property (@(posedge clk) disable iff (rst)
        n_error |-> !zero_pulse);

    // R8: a legal load clears the error flag
    a_r8_legal_clears: assert property (@(posedge clk) disable iff (rst)
        (preset_load && (n_preset != '0)) |=> !n_error);

endmodule

bind synth_clk_divider synth_clk_divider_chk #(.N_W(N_W)) chk_i (.*);

// File: tb/synth_clk_divider_tb_top.sv
module synth_clk_divider_tb_top;

    typedef struct packed {
        logic [1:0] sel;
        logic       route;
        logic [3:0] n;
        logic [3:0] gap;
    } vec_t;

    // sel, route, N, aux gap (0 = never)
    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b1, 4'd2,  4'd1},
        '{2'd1, 1'b1, 4'd3,  4'd0},
        '{2'd2, 1'b1, 4'd1,  4'd0},
        '{2'd3, 1'b1, 4'd2,  4'd2},
        '{2'd0, 1'b0, 4'd7,  4'd3},
        '{2'd3, 1'b0, 4'd15, 4'd1},
        '{2'd1, 1'b0, 4'd1,  4'd2},
        '{2'd2, 1'b0, 4'd4,  4'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ratio_sel = 2'd0;
    logic       route_casc = 1'b1;
    logic [3:0] n_preset = 4'd1;
    logic       preset_load = 1'b0;
    logic       aux_step = 1'b0;
    logic       fb_out, zero_pulse, casc_out, n_error;

    int nchk = 0;
    int nfail = 0;
    int aux_gap = 0;

    always #5 clk = ~clk;

    synth_clk_divider dut_i (
        .clk         (clk),
        .rst         (rst),
        .ratio_sel   (ratio_sel),
        .route_casc  (route_casc),
        .n_preset    (n_preset),
        .preset_load (preset_load),
        .aux_step    (aux_step),
        .fb_out      (fb_out),
        .zero_pulse  (zero_pulse),
        .casc_out    (casc_out),
        .n_error     (n_error)
    );

    // auxiliary step generator: one strobe every aux_gap clocks
    initial begin
        int acnt = 0;
        forever begin
            @(negedge clk);
            if (aux_gap == 0) begin
                aux_step = 1'b0;
                acnt = 0;
            end else begin
                acnt++;
                if (acnt >= aux_gap) begin
                    aux_step = 1'b1;
                    acnt = 0;
                end else begin
                    aux_step = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 16;
            2'd2: return 64;
            default: return 100;
        endcase
    endfunction

    function automatic logic sig(input int w);
        case (w)
            0: return fb_out;
            1: return zero_pulse;
            default: return casc_out;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // period between two pulses of the chosen output, sampled at negedges
    task automatic measure(input int w, output int per);
        int t = 0;
        while (!sig(w) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!sig(w) && per < 5000);
    endtask

    // count negedges after the current one until the output goes high
    task automatic latency(input int w, output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!sig(w) && lat < 5000);
    endtask

    task automatic load_cfg(input logic [1:0] s, input logic r, input logic [3:0] n, input int g);
        @(negedge clk);
        ratio_sel = s;
        route_casc = r;
        n_preset = n;
        aux_gap = g;
        preset_load = 1'b1;
        @(negedge clk);
        preset_load = 1'b0;
    endtask

    initial begin
        int per;
        int lat;
        int cnt;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset fb_out", int'(fb_out), 0);
        chk("R9 reset zero_pulse", int'(zero_pulse), 0);
        chk("R9 reset casc_out", int'(casc_out), 0);
        chk("R9 reset n_error", int'(n_error), 0);
        rst = 1'b0;

        // table walk: R1 R4 R5 R10
        for (int i = 0; i < 8; i++) begin
            load_cfg(VECS[i].sel, VECS[i].route, VECS[i].n, int'(VECS[i].gap));
            measure(0, per);
            if (VECS[i].route)
                chk("R4/R10 table fb period", per, ratio_of(VECS[i].sel) * int'(VECS[i].n));
            else
                chk("R5 table fb period", per, ratio_of(VECS[i].sel));
            measure(1, per);
            if (VECS[i].route)
                chk("R6 table zero period", per, ratio_of(VECS[i].sel) * int'(VECS[i].n));
            else if (VECS[i].gap != 0)
                chk("R5 table zero period", per, int'(VECS[i].gap) * int'(VECS[i].n));
            measure(2, per);
            chk("R1 table casc period", per, ratio_of(VECS[i].sel));
        end

        // full sweep, cascaded (R4) and independent (R5)
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n < 16; n++) begin
                load_cfg(2'(s), 1'b1, 4'(n), 0);
                measure(0, per);
                chk("R4 sweep cascaded period", per, ratio_of(2'(s)) * n);
                load_cfg(2'(s), 1'b0, 4'(n), 1);
                measure(1, per);
                chk("R5 sweep independent zero period", per, n);
            end
            measure(0, per);
            chk("R5 sweep independent fb period", per, ratio_of(2'(s)));
        end

        // R2: select change restarts the prescaler
        load_cfg(2'd3, 1'b1, 4'd1, 0);
        measure(2, per);
        repeat (10) @(negedge clk);
        ratio_sel = 2'd0;
        latency(2, lat);
        chk("R2 restart latency", lat, 4);

        // R7: illegal zero preset
        load_cfg(2'd0, 1'b1, 4'd0, 1);
        chk("R7 n_error raised", int'(n_error), 1);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (zero_pulse || fb_out) cnt++;
        end
        chk("R7 no pulses while halted", cnt, 0);
        load_cfg(2'd0, 1'b1, 4'd5, 0);
        chk("R8 n_error cleared", int'(n_error), 0);
        measure(0, per);
        chk("R8 period after recovery", per, 20);

        // R8: first zero latency after load, stepping every clock
        load_cfg(2'd1, 1'b0, 4'd6, 1);
        @(negedge clk);
        aux_gap = 1;
        load_cfg(2'd1, 1'b0, 4'd3, 1);
        // load_cfg returns one negedge after the load edge
        lat = 1;
        while (!zero_pulse && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 first zero after load", lat, 3);

        // R9: reset mid-run, then reload
        load_cfg(2'd0, 1'b0, 4'd4, 1);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset zero_pulse", int'(zero_pulse), 0);
        chk("R9 mid reset fb_out", int'(fb_out), 0);
        chk("R9 mid reset n_error", int'(n_error), 0);
        rst = 1'b0;
        latency(1, lat);
        chk("R9 first zero after release", lat, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule